// File: doc/BRIEF.md
# Late-Write Pipelined-Read Synchronous SRAM

This block is a synchronous static memory core with a small parameterized array, organised as a word of several bytes. The default is two 8-bit bytes and 64 words. On every rising clock edge it decodes one command from a handful of control inputs:

- a sleep input
- an active-low chip select
- an active-low write strobe
- one active-low enable per byte
- an active-low output enable
- a continue input

Reads are pipelined. The word read on one edge comes out of a data register after the next edge. Writes are late. The address and byte enables are taken with the command, and the write data is taken from the input bus one edge later.

The data bus is split into an input bus, an output bus and an output-drive flag. The flag stands in for the tristate control of a shared pin. When the flag is low, the surrounding logic must treat the output bus as undriven.

After a read or a write opens a burst, continue commands step an internal 2-bit offset through the low address bits. Each continue makes one more beat of the same kind. After four beats the address wraps back to the base address. When a read hits the word that the previous write is finishing, a bypass path returns the new data.

Top module: `lw_sram`

## Requirements
- R1: A synchronous active-high reset clears the output-drive flag, any pending write and any open burst. Memory contents are not cleared. After reset, `doe_o` is 0.
- R2: While `sleep_i` is 1, `doe_o` is 0 in that same cycle. The command is ignored: no read, no new write and no change to the burst. A write data phase already owed from the previous edge still completes.
- R3: With `sleep_i`=0 and `sel_n_i`=1 on an edge, the command is a deselect. `doe_o` is 0 after that edge, and any open burst ends.
- R4: With `sel_n_i`=0, `adv_i`=0 and `wr_n_i`=1, the word at `addr_i` appears on `dout_o` after the edge. `doe_o` is 1 only if `oe_n_i` was 0 at that edge; otherwise `doe_o` is 0.
- R5: With `sel_n_i`=0, `adv_i`=0, `wr_n_i`=0 and `be_n_i` all 0, the whole word at `addr_i` takes the value on `din_i` at the next edge.
- R6: In a write, byte b (bits 8b+7..8b) is updated only when `be_n_i[b]` is 0. The other bytes keep their old value.
- R7: A write whose byte enables are all 1 is aborted. No byte changes, and `doe_o` is 0 after the edge.
- R8: Output turn-off happens one full cycle after a write, deselect or sleep command. During the cycle that ends with that edge, `doe_o` and `dout_o` still show the result of the earlier command.
- R9: Inside an open burst, a continue (`sel_n_i`=0, `adv_i`=1) adds one, modulo 4, to the low 2 address bits of the base address. The upper bits stay fixed. The continue repeats the burst's kind (read or write), and uses the `oe_n_i` or `be_n_i` present with it.
- R10: The fourth continue after the opening command wraps the beat address back to the base address.
- R11: A read of the word written by the previous edge's write command returns the newly written data, merged bytewise.
- R12: A continue with no open burst (after reset or after a deselect) does nothing, and `doe_o` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep: ignore the command and turn the outputs off |
| sel_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| be_n_i | input | NB (2) | Active-low byte enables, bit b for byte b |
| oe_n_i | input | 1 | Active-low output enable for reads |
| adv_i | input | 1 | Continue the open burst |
| addr_i | input | AW (6) | Word address |
| din_i | input | NB*BW (16) | Write data, taken one edge after the write command |
| dout_o | output | NB*BW (16) | Registered read data |
| doe_o | output | 1 | Output-drive flag for `dout_o` |

## Verification
A behavioural reference model tracks the memory contents, the owed write and the burst offset, and it is compared with the design on every clock. The first stimulus fills the memory with four-beat write bursts, which shows that offsets step through the low address bits and leave the upper bits alone. Directed sequences then pair each write kind (full, partial, aborted) with a readback. This separates a correct byte mask from one that is inverted or ignored, and a correct late capture from one that takes data on the command edge. A read right after a write to the same word tells a working bypass from a stale array read. Five-beat read bursts, deselects, continues with no open burst, and sleeps inserted mid-sequence check the wrap, the output turn-off timing and the cases that must be ignored. A long random mix of all commands finishes the run.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // kind of the burst currently open
    typedef enum logic [1:0] {
        BURST_NONE = 2'd0,
        BURST_RD   = 2'd1,
        BURST_WR   = 2'd2
    } burst_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_i,
    input  logic          sel_n_i,
    input  logic          wr_n_i,
    input  logic [NB-1:0] be_n_i,
    input  logic          oe_n_i,
    input  logic          adv_i,
    input  logic [AW-1:0] addr_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [NB-1:0] wr_be_o,
    output logic          drive_o
);

    localparam int HI = AW - 2;

    typedef struct packed {
        burst_e        kind;
        logic [AW-1:0] base;
        logic [1:0]    off;
        logic          wpend;
        logic [AW-1:0] waddr;
        logic [NB-1:0] wbe;
        logic          drive;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [1:0]    off_nx;
    logic [AW-1:0] beat_addr;

    always_comb begin
        st_d      = st_q;
        st_d.wpend = 1'b0;
        st_d.drive = 1'b0;
        rd_en_o   = 1'b0;
        rd_addr_o = addr_i;
        off_nx    = st_q.off + 2'd1;
        beat_addr = {st_q.base[AW-1:2], st_q.base[1:0] + off_nx};
        if (!sleep_i) begin
            if (sel_n_i) begin
                st_d.kind = BURST_NONE;
            end else if (adv_i) begin
                if (st_q.kind != BURST_NONE) begin
                    st_d.off = off_nx;
                    if (st_q.kind == BURST_RD) begin
                        rd_en_o    = 1'b1;
                        rd_addr_o  = beat_addr;
                        st_d.drive = !oe_n_i;
                    end else begin
                        st_d.wpend = !(&be_n_i);
                        st_d.waddr = beat_addr;
                        st_d.wbe   = ~be_n_i;
                    end
                end
            end else begin
                st_d.base = addr_i;
                st_d.off  = 2'd0;
                if (wr_n_i) begin
                    st_d.kind  = BURST_RD;
                    rd_en_o    = 1'b1;
                    rd_addr_o  = addr_i;
                    st_d.drive = !oe_n_i;
                end else begin
                    st_d.kind  = BURST_WR;
                    st_d.wpend = !(&be_n_i);
                    st_d.waddr = addr_i;
                    st_d.wbe   = ~be_n_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.kind  <= BURST_NONE;
            st_q.base  <= '0;
            st_q.off   <= 2'd0;
            st_q.wpend <= 1'b0;
            st_q.waddr <= '0;
            st_q.wbe   <= '0;
            st_q.drive <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = st_q.wpend;
    assign wr_addr_o = st_q.waddr;
    assign wr_be_o   = st_q.wbe;
    assign drive_o   = st_q.drive;

    // R2
    sleep_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> !wr_en_o);

    // R3
    deselect_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && sel_n_i) |=> !drive_o);

    // R4
    read_oe_high_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !sel_n_i && !adv_i && wr_n_i && oe_n_i) |=> !drive_o);

    // R5
    full_write_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !sel_n_i && !adv_i && !wr_n_i && (be_n_i == '0))
        |=> (wr_en_o && (wr_be_o == {NB{1'b1}})));

    // R9
    burst_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !sel_n_i && adv_i && (st_q.kind != BURST_NONE))
        |=> ((st_q.off == $past(st_q.off) + 2'd1) && (st_q.base == $past(st_q.base))));

    // R7
    abort_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !sel_n_i && (&be_n_i) && (!wr_n_i || adv_i)) |=> !wr_en_o);

    if (HI < 0) begin : g_bad_aw
        initial $error("AW must be at least 2");
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [NB-1:0]    wr_be_i,
    input  logic [NB*BW-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [NB*BW-1:0] rd_data_o
);

    localparam int DW    = NB * BW;
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rdata_d, rdata_q;
    logic [DW-1:0] stored;
    logic          hit;

    assign stored = mem[rd_addr_i];
    assign hit    = wr_en_i && (wr_addr_i == rd_addr_i);

    // read path with late-write bypass, byte by byte
    for (genvar b = 0; b < NB; b++) begin : g_byp
        always_comb begin
            if (!rd_en_i)
                rdata_d[b*BW +: BW] = rdata_q[b*BW +: BW];
            else if (hit && wr_be_i[b])
                rdata_d[b*BW +: BW] = wr_data_i[b*BW +: BW];
            else
                rdata_d[b*BW +: BW] = stored[b*BW +: BW];
        end

        always_ff @(posedge clk) begin
            if (wr_en_i && wr_be_i[b])
                mem[wr_addr_i][b*BW +: BW] <= wr_data_i[b*BW +: BW];
        end
    end

    always_ff @(posedge clk) begin
        rdata_q <= rdata_d;
    end

    assign rd_data_o = rdata_q;

    // R11
    bypass_data_chk: assert property (@(posedge clk)
        (rd_en_i && hit && (wr_be_i == {NB{1'b1}})) |=> (rd_data_o == $past(wr_data_i)));

endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_i,
    input  logic             sel_n_i,
    input  logic             wr_n_i,
    input  logic [NB-1:0]    be_n_i,
    input  logic             oe_n_i,
    input  logic             adv_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NB*BW-1:0] din_i,
    output logic [NB*BW-1:0] dout_o,
    output logic             doe_o
);

    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [NB-1:0] wr_be;
    logic          drive;

    lw_sram_ctrl #(.AW(AW), .NB(NB)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .sleep_i   (sleep_i),
        .sel_n_i   (sel_n_i),
        .wr_n_i    (wr_n_i),
        .be_n_i    (be_n_i),
        .oe_n_i    (oe_n_i),
        .adv_i     (adv_i),
        .addr_i    (addr_i),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_be_o   (wr_be),
        .drive_o   (drive)
    );

    lw_sram_array #(.AW(AW), .NB(NB), .BW(BW)) array_i (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_be_i   (wr_be),
        .wr_data_i (din_i),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (dout_o)
    );

    assign doe_o = drive && !sleep_i;

    // R1
    reset_off_chk: assert property (@(posedge clk) rst |=> !doe_o);

    // R12
    idle_continue_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && sel_n_i) ##1 (!sleep_i && !sel_n_i && adv_i) |=> !doe_o);

endmodule

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int DW = NB * BW;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_i = 1'b0;
    logic          sel_n_i = 1'b1;
    logic          wr_n_i = 1'b1;
    logic [NB-1:0] be_n_i = '1;
    logic          oe_n_i = 1'b1;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dout_o;
    logic          doe_o;

    always #10 clk = ~clk;

    lw_sram #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .sel_n_i(sel_n_i),
        .wr_n_i(wr_n_i), .be_n_i(be_n_i), .oe_n_i(oe_n_i), .adv_i(adv_i),
        .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o), .doe_o(doe_o)
    );

    // reference model state
    logic [DW-1:0] rmem [WORDS];
    int            pq_addr[$];
    logic [NB-1:0] pq_mask[$];
    int            b_kind;
    int            b_base;
    int            b_off;
    logic          exp_doe;
    logic [DW-1:0] exp_dout;
    string         prev_tag = "R1";
    int            checks = 0;
    int            fails = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic model_step();
        int a;
        if (pq_addr.size() > 0) begin
            a = pq_addr.pop_front();
            for (int b = 0; b < NB; b++)
                if (pq_mask[0][b]) rmem[a][b*BW +: BW] = din_i[b*BW +: BW];
            void'(pq_mask.pop_front());
        end
        exp_doe = 1'b0;
        if (!sleep_i) begin
            if (sel_n_i) begin
                b_kind = 0;
            end else if (adv_i) begin
                if (b_kind != 0) begin
                    b_off = (b_off + 1) % 4;
                    a = (b_base & ~3) | ((b_base + b_off) & 3);
                    if (b_kind == 1) begin
                        exp_doe  = !oe_n_i;
                        exp_dout = rmem[a];
                    end else if (be_n_i != '1) begin
                        pq_addr.push_back(a);
                        pq_mask.push_back(~be_n_i);
                    end
                end
            end else begin
                b_base = int'(addr_i);
                b_off  = 0;
                if (wr_n_i) begin
                    b_kind   = 1;
                    exp_doe  = !oe_n_i;
                    exp_dout = rmem[addr_i];
                end else begin
                    b_kind = 2;
                    if (be_n_i != '1) begin
                        pq_addr.push_back(int'(addr_i));
                        pq_mask.push_back(~be_n_i);
                    end
                end
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (doe_o !== exp_doe) begin
            fails++;
            $display("FAIL %s: doe_o actual %b expected %b", tag, doe_o, exp_doe);
        end else if (exp_doe && (dout_o !== exp_dout)) begin
            fails++;
            $display("FAIL %s: dout_o actual %h expected %h", tag, dout_o, exp_dout);
        end
    endtask

    // one clock: compare last result, drive, check sleep gating, clock model
    task automatic cyc(input logic sl, input logic sn, input logic wn,
                       input logic [NB-1:0] ben, input logic oen, input logic adv,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        compare(prev_tag);
        sleep_i = sl; sel_n_i = sn; wr_n_i = wn; be_n_i = ben;
        oe_n_i = oen; adv_i = adv; addr_i = ad; din_i = d;
        #2;
        if (sl) begin
            checks++;
            if (doe_o !== 1'b0) begin
                fails++;
                $display("FAIL R2: doe_o during sleep actual %b expected 0", doe_o);
            end
        end
        @(posedge clk);
        model_step();
        prev_tag = tag;
    endtask

    task automatic rd(input logic [AW-1:0] ad, input logic [DW-1:0] d, input string tag);
        cyc(0, 0, 1, '1, 0, 0, ad, d, tag);
    endtask
    task automatic wr(input logic [AW-1:0] ad, input logic [NB-1:0] ben,
                      input logic [DW-1:0] d, input string tag);
        cyc(0, 0, 0, ben, 1, 0, ad, d, tag);
    endtask
    task automatic cont(input logic [NB-1:0] ben, input logic oen,
                        input logic [DW-1:0] d, input string tag);
        cyc(0, 0, 1, ben, oen, 1, '0, d, tag);
    endtask
    task automatic desel(input logic [DW-1:0] d, input string tag);
        cyc(0, 1, 1, '1, 0, 0, '0, d, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run actual hung expected finish");
        summary();
    end

    initial begin
        b_kind = 0; b_base = 0; b_off = 0;
        exp_doe = 1'b0; exp_dout = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        // R12: continue with no open burst after reset
        cont('1, 0, 16'h0, "R12");
        // R9 fill memory with write bursts of four beats
        for (int g = 0; g < WORDS / 4; g++) begin
            wr(AW'(g * 4 + 1), '0, 16'h0, "R9");
            cont('0, 1, 16'(16'hA000 + g * 16 + 1), "R9");
            cont('0, 1, 16'(16'hA000 + g * 16 + 2), "R9");
            cont('0, 1, 16'(16'hA000 + g * 16 + 3), "R9");
            desel(16'(16'hA000 + g * 16 + 0), "R3");
        end
        // R5 full write then read back
        wr(6'd5, 2'b00, 16'h0, "R5");
        desel(16'h1234, "R5");
        rd(6'd5, 16'h0, "R5");
        // R6 partial writes, low byte then high byte
        wr(6'd5, 2'b10, 16'h0, "R6");
        desel(16'hFFEE, "R6");
        rd(6'd5, 16'h0, "R6");
        wr(6'd5, 2'b01, 16'h0, "R6");
        desel(16'h77CC, "R6");
        rd(6'd5, 16'h0, "R6");
        // R7 abort, then readback shows no change
        wr(6'd5, 2'b11, 16'h0, "R7");
        desel(16'hDEAD, "R7");
        rd(6'd5, 16'h0, "R7");
        // R4 read with output enable high stays off
        cyc(0, 0, 1, '1, 1, 0, 6'd9, 16'h0, "R4");
        rd(6'd9, 16'h0, "R4");
        // R8 read then write: output holds one cycle, then turns off
        rd(6'd10, 16'h0, "R8");
        wr(6'd10, 2'b00, 16'h0, "R8");
        // R11 read right after write to same word (bypass)
        rd(6'd10, 16'h5A5A, "R11");
        wr(6'd11, 2'b01, 16'h0, "R11");
        rd(6'd11, 16'hC3C3, "R11");
        // R10 read burst with five beats wraps to base
        rd(6'd14, 16'h0, "R10");
        cont('1, 0, 16'h0, "R10");
        cont('1, 0, 16'h0, "R10");
        cont('1, 1, 16'h0, "R9");
        cont('1, 0, 16'h0, "R10");
        // R3 deselect ends burst; following continue is idle (R12)
        desel(16'h0, "R3");
        cont('1, 0, 16'h0, "R12");
        // R2 sleep after a driving read, and sleep in the middle of a burst
        rd(6'd20, 16'h0, "R2");
        cyc(1, 0, 0, 2'b00, 0, 0, 6'd20, 16'h0, "R2");
        rd(6'd20, 16'h0, "R2");
        wr(6'd21, 2'b00, 16'h0, "R2");
        cyc(1, 0, 1, '1, 0, 0, 6'd33, 16'hBEEF, "R2");
        rd(6'd21, 16'h0, "R2");
        // random mix of all commands
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            cyc((r == 0), (r == 1), ($urandom_range(0, 1) == 1),
                NB'($urandom), ($urandom_range(0, 3) == 0), (r >= 6),
                AW'($urandom), DW'($urandom), "R11");
        end
        desel(16'h0, "R3");
        @(negedge clk);
        compare(prev_tag);
        summary();
    end

endmodule